// File: doc/BRIEF.md
# Addressed Serial Divider-Programming Port

This block takes a three-wire serial programming stream (a bit clock, a data line and a load strobe) and turns it into three synthesizer divide ratios: a 14-bit reference divider value, a 10-bit main divider value and a 7-bit swallow divider value. The stream reaches the block only while a 3-bit module-select code on the shared address lines matches this block's code. All three serial lines are brought into the system clock domain through synchronizers, and their rising edges are detected there.

A frame holds 32 bits. The reference value comes first, MSB first. The main value follows, then the swallow value, and a single control bit comes last. A rising load strobe copies the frame into the output latches only when that trailing control bit is 1. A successful copy raises a one-cycle `newData` strobe. Every accepted load edge also raises a loop-filter bypass request, which stays high for a programmable number of system clocks so the phase-locked loop can settle faster.

Top module: `synprog_port`

## Requirements
- R1: While `rstN` is low and after its release, `rDiv`, `nDiv` and `aDiv` read zero and `newData` and `bypassReq` are low until the first commit or accepted load edge.
- R2: Each rising edge of `serClk` seen while the address matches shifts the level of `serData` into the frame register.
- R3: After 32 shifted bits, the first 14 bits (MSB first) form `rDiv`, the next 10 bits form `nDiv`, the next 7 bits form `aDiv`, and the 32nd bit is the control bit.
- R4: A rising edge of `serLoad` seen while the address matches, with the control bit equal to 1, updates `rDiv`, `nDiv` and `aDiv` at the third system clock edge after the edge that first samples the high level.
- R5: A load edge that finds the control bit at 0 leaves `rDiv`, `nDiv` and `aDiv` unchanged.
- R6: The address matches only when `modAddr[0]`=1, `modAddr[1]`=1 and `modAddr[2]`=0. With any other code, clock edges shift nothing and load edges commit nothing and raise no bypass request.
- R7: `newData` is high for exactly one system clock cycle per commit, and in the same cycle as the new latch values first appear.
- R8: Every accepted load edge, whether the control bit is 0 or 1, raises `bypassReq` in the cycle the latches would update. `bypassReq` then stays high for exactly `BYPASS_CYCLES` cycles, and a new accepted edge restarts the count.
- R9: Only the 32 most recent shifted bits matter. Extra bits sent before a frame are pushed out.
- R10: A load strobe held high for many cycles counts as one edge and gives one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data line, asynchronous |
| serLoad | input | 1 | Serial load strobe, asynchronous |
| modAddr | input | 3 | Module select code, bit 0 is the first address line |
| rDiv | output | 14 | Latched reference divide ratio |
| nDiv | output | 10 | Latched main divide ratio |
| aDiv | output | 7 | Latched swallow divide ratio |
| newData | output | 1 | One-cycle strobe on commit |
| bypassReq | output | 1 | Loop-filter bypass request |

## Verification
Every serial input passes two synchronizer flops and one edge-history flop. Its effect therefore appears at the third system clock edge after the edge that first samples it: a shift, a latch update, the `newData` pulse and the start of `bypassReq` all land there. The bench keeps a behavioural model that delays its sampled inputs by that same depth and compares all outputs on every falling clock edge, half a cycle after the registers settle. Scenario checks, made once the stream has gone quiet, confirm absolute latch values, pulse counts and the exact bypass duration.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } ctrl_strobe_t;
endpackage

// File: rtl/synprog_sync.sv
module synprog_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= din;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/synprog_ctrl.sv
module synprog_ctrl
  import synprog_pkg::*;
#(
  parameter int         SYNC_STAGES   = 2,
  parameter int         BYPASS_CYCLES = 16,
  parameter logic [2:0] ADDR_CODE     = 3'b011
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serData,
  input  logic         serLoad,
  input  logic [2:0]   modAddr,
  input  logic         ctrlBit,
  output ctrl_strobe_t strobes,
  output logic         bypassReq
);
  localparam int CNT_W = $clog2(BYPASS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BYPASS_CYCLES);

  logic [5:0] rawIn, syncIn;
  logic       clkS, dataS, loadS;
  logic [2:0] addrS;
  logic       clkPrev, loadPrev;
  logic       gateOpen, clkRise, loadRise, loadAccepted;
  logic [CNT_W-1:0] bypassCnt;

  assign rawIn = {modAddr, serLoad, serData, serClk};

  synprog_sync #(.WIDTH(6), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign {addrS, loadS, dataS, clkS} = syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
    end
  end

  assign gateOpen     = (addrS == ADDR_CODE);
  assign clkRise      = clkS & ~clkPrev;
  assign loadRise     = loadS & ~loadPrev;
  assign loadAccepted = loadRise & gateOpen;

  always_comb begin
    strobes.shiftEn  = clkRise & gateOpen;
    strobes.shiftBit = dataS;
    strobes.commit   = loadAccepted & ctrlBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bypassCnt <= '0;
    else if (loadAccepted)    bypassCnt <= CNT_LOAD;
    else if (bypassCnt != '0) bypassCnt <= bypassCnt - 1'b1;
  end

  assign bypassReq = (bypassCnt != '0);

  // R8: an accepted load edge raises the bypass request on the next cycle
  p_bypass_starts_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadAccepted |=> bypassReq);

  // R10: two load edges cannot be seen on consecutive cycles
  p_single_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadRise |=> !loadRise);
endmodule

// File: rtl/synprog_datapath.sv
module synprog_datapath
  import synprog_pkg::*;
#(
  parameter int R_W = 14,
  parameter int N_W = 10,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrl_strobe_t   strobes,
  output logic           ctrlBit,
  output logic [R_W-1:0] rDiv,
  output logic [N_W-1:0] nDiv,
  output logic [A_W-1:0] aDiv,
  output logic           newData
);
  localparam int FRAME_W = R_W + N_W + A_W + 1;
  localparam int A_LO    = 1;
  localparam int N_LO    = A_LO + A_W;
  localparam int R_LO    = N_LO + N_W;

  logic [FRAME_W-1:0] frameSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                frameSr <= '0;
    else if (strobes.shiftEn) frameSr <= {frameSr[FRAME_W-2:0], strobes.shiftBit};
  end

  assign ctrlBit = frameSr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rDiv    <= '0;
      nDiv    <= '0;
      aDiv    <= '0;
      newData <= 1'b0;
    end else begin
      newData <= strobes.commit;
      if (strobes.commit) begin
        rDiv <= frameSr[R_LO +: R_W];
        nDiv <= frameSr[N_LO +: N_W];
        aDiv <= frameSr[A_LO +: A_W];
      end
    end
  end

  // R5: without a commit the latched ratios hold
  p_hold_without_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(rDiv) && $stable(nDiv) && $stable(aDiv)));

  // R4: a commit only occurs with the trailing control bit set
  p_commit_needs_ctrl_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> frameSr[0]);

  // R7: the new-data strobe lasts one cycle
  p_newdata_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    newData |=> !newData);
endmodule

// File: rtl/synprog_port.sv
module synprog_port
  import synprog_pkg::*;
#(
  parameter int         R_W           = 14,
  parameter int         N_W           = 10,
  parameter int         A_W           = 7,
  parameter int         SYNC_STAGES   = 2,
  parameter int         BYPASS_CYCLES = 16,
  parameter logic [2:0] ADDR_CODE     = 3'b011
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic [2:0]     modAddr,
  output logic [R_W-1:0] rDiv,
  output logic [N_W-1:0] nDiv,
  output logic [A_W-1:0] aDiv,
  output logic           newData,
  output logic           bypassReq
);
  ctrl_strobe_t strobes;
  logic         ctrlBit;

  synprog_ctrl #(
    .SYNC_STAGES   (SYNC_STAGES),
    .BYPASS_CYCLES (BYPASS_CYCLES),
    .ADDR_CODE     (ADDR_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .serLoad   (serLoad),
    .modAddr   (modAddr),
    .ctrlBit   (ctrlBit),
    .strobes   (strobes),
    .bypassReq (bypassReq)
  );

  synprog_datapath #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ctrlBit (ctrlBit),
    .rDiv    (rDiv),
    .nDiv    (nDiv),
    .aDiv    (aDiv),
    .newData (newData)
  );

  // R8: every commit coincides with an active bypass request
  p_newdata_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    newData |-> bypassReq);
endmodule

// File: tb/synprog_port_tb.sv
module synprog_port_tb;
  localparam int BYP = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic [2:0]  modAddr = 3'b011;
  logic [13:0] rDiv;
  logic [9:0]  nDiv;
  logic [6:0]  aDiv;
  logic        newData, bypassReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int newCnt = 0;
  int bypCnt = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  synprog_port #(.BYPASS_CYCLES(BYP)) u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .modAddr(modAddr), .rDiv(rDiv), .nDiv(nDiv),
    .aDiv(aDiv), .newData(newData), .bypassReq(bypassReq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          bitQ[$];
  logic [5:0]  h1 = '0, h2 = '0, h3 = '0;
  int          mR = 0, mN = 0, mA = 0, mBy = 0;
  bit          mNew = 1'b0;

  function automatic int bitAt(int p);
    return (p < bitQ.size()) ? bitQ[bitQ.size() - 1 - p] : 0;
  endfunction

  function automatic int field(int lo, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v += bitAt(lo + i) << i;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      bitQ.delete();
      h1 = '0; h2 = '0; h3 = '0;
      mR = 0; mN = 0; mA = 0; mBy = 0; mNew = 1'b0;
    end else begin
      bit gate, cR, lR;
      gate = (h2[5:3] == 3'b011);
      cR   = h2[0] && !h3[0];
      lR   = h2[2] && !h3[2];
      mNew = 1'b0;
      if (mBy > 0) mBy--;
      if (lR && gate) begin
        mBy = BYP;
        if (bitAt(0) == 1) begin
          mR = field(18, 14); mN = field(8, 10); mA = field(1, 7);
          mNew = 1'b1;
        end
      end
      if (cR && gate) begin
        bitQ.push_back(int'(h2[1]));
        if (bitQ.size() > 32) void'(bitQ.pop_front());
      end
      h3 = h2; h2 = h1;
      h1 = {modAddr, serLoad, serData, serClk};
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (newData) newCnt++;
    if (bypassReq) bypCnt++;
    if (!done) begin
      check(rDiv == 14'(mR), "R3/R4 rDiv", rDiv, mR);
      check(nDiv == 10'(mN), "R3/R4 nDiv", nDiv, mN);
      check(aDiv == 7'(mA),  "R3/R4 aDiv", aDiv, mA);
      check(newData == mNew, "R7 newData", newData, mNew);
      check(bypassReq == (mBy > 0), "R8 bypassReq", bypassReq, mBy > 0);
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    serData = b; serClk = 1'b0; waitCyc(3);
    serClk = 1'b1; waitCyc(3);
    serClk = 1'b0;
  endtask

  task automatic sendFrame(int r, int n, int a, bit c);
    for (int i = 13; i >= 0; i--) sendBit(r[i]);
    for (int i = 9; i >= 0; i--)  sendBit(n[i]);
    for (int i = 6; i >= 0; i--)  sendBit(a[i]);
    sendBit(c);
    waitCyc(4);
  endtask

  task automatic pulseLoad(int hold);
    serLoad = 1'b1; waitCyc(hold);
    serLoad = 1'b0; waitCyc(BYP + 8);
  endtask

  task automatic expectRatios(int r, int n, int a, string tag);
    check(rDiv == 14'(r), tag, rDiv, r);
    check(nDiv == 10'(n), tag, nDiv, n);
    check(aDiv == 7'(a),  tag, aDiv, a);
  endtask

  initial begin
    waitCyc(4);
    // R1: reset state
    expectRatios(0, 0, 0, "R1 reset");
    check(!newData && !bypassReq, "R1 strobes", {newData, bypassReq}, 0);
    rstN = 1'b1;
    waitCyc(4);
    expectRatios(0, 0, 0, "R1 after release");

    // R2/R3/R4/R7: nominal frame, commit
    sendFrame(2560, 520, 27, 1'b1);
    newCnt = 0; bypCnt = 0;
    pulseLoad(4);
    expectRatios(2560, 520, 27, "R2/R3/R4 nominal frame");
    check(newCnt == 1, "R7 newData count", newCnt, 1);
    check(bypCnt == BYP, "R8 bypass length", bypCnt, BYP);

    // R3 boundary: all ones
    sendFrame(16383, 1023, 127, 1'b1);
    pulseLoad(4);
    expectRatios(16383, 1023, 127, "R3 all-ones frame");

    // R5: control bit zero, still bypass
    sendFrame(100, 200, 30, 1'b0);
    newCnt = 0; bypCnt = 0;
    pulseLoad(4);
    expectRatios(16383, 1023, 127, "R5 control bit zero");
    check(newCnt == 0, "R5 no newData", newCnt, 0);
    check(bypCnt == BYP, "R8 bypass on ctrl zero", bypCnt, BYP);

    // R6: mismatched address blocks everything
    modAddr = 3'b111;
    waitCyc(4);
    sendFrame(5, 6, 7, 1'b1);
    newCnt = 0; bypCnt = 0;
    pulseLoad(4);
    expectRatios(16383, 1023, 127, "R6 mismatch frame");
    check(bypCnt == 0, "R6 no bypass", bypCnt, 0);
    modAddr = 3'b011;
    waitCyc(4);
    pulseLoad(4);
    expectRatios(16383, 1023, 127, "R6 bits were not shifted");
    check(newCnt == 0, "R6 no newData", newCnt, 0);

    // R9: leading junk bits pushed out
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendFrame(1234, 345, 64, 1'b1);
    pulseLoad(4);
    expectRatios(1234, 345, 64, "R9 extra leading bits");

    // R10: long load pulse, one commit; R8 restart
    sendFrame(777, 88, 9, 1'b1);
    newCnt = 0;
    pulseLoad(40);
    expectRatios(777, 88, 9, "R10 long load");
    check(newCnt == 1, "R10 single commit", newCnt, 1);

    bypCnt = 0;
    serLoad = 1'b1; waitCyc(3); serLoad = 1'b0; waitCyc(5);
    serLoad = 1'b1; waitCyc(3); serLoad = 1'b0; waitCyc(BYP + 10);
    check(bypCnt == BYP + 8, "R8 bypass restart", bypCnt, BYP + 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule